// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block holds a small pool of waiting instructions for an out-of-order core. A dispatch port places one instruction per cycle into a free slot. Each instruction carries an opcode, two source operands and the number of the reorder-buffer slot reserved for its result. When a source operand is already known, its value is stored. When it is not, the slot stores the reorder-buffer tag of the producing instruction. Every slot watches a result broadcast bus that carries a tag and a value. When a broadcast tag matches a source operand that is still waiting, the slot takes the value.

A slot whose two operands are both present competes for the single issue output. The oldest competing slot by dispatch order wins. It is sent out on registered issue outputs together with its reorder-buffer destination, and the slot is released in the same cycle. When every slot is occupied, dispatch is held off through a not-ready indication. A flush pulse empties the whole pool at once.

Top module: `rsv_station`

## Requirements
- R1: An instruction offered with `disp_valid` high while `disp_ready` is high is stored and later appears on the issue outputs with its own opcode (`iss_op`) and its two operand values (`iss_src_a`, `iss_src_b`).
- R2: `disp_ready` is low exactly when all DEPTH slots are occupied. An instruction offered while `disp_ready` is low is dropped and never issues.
- R3: For each source, a ready flag of 1 at dispatch means the supplied value is used as it is. A flag of 0 means the operand waits on the supplied tag.
- R4: `iss_dst` equals the reorder-buffer destination number that was given at dispatch for that instruction.
- R5: A broadcast whose tag equals a waiting operand's tag fills that operand, and one broadcast may fill both operands of a slot. A broadcast with a non-matching tag changes nothing. An operand that was ready at dispatch keeps its value even when a broadcast carries the tag given with it.
- R6: A slot issues only when both operands are present. A slot made complete at clock edge k (by dispatch or by broadcast) shows `iss_valid` high after edge k+1, provided it is the oldest complete slot.
- R7: A broadcast in the same cycle as the dispatch of an instruction that waits on that tag fills the dispatched operand directly.
- R8: At most one slot issues per cycle. Among complete slots, the one dispatched earliest issues first, whatever slot position it occupies.
- R9: A cycle with `flush` high empties every slot, drops any dispatch in that cycle and issues nothing. `iss_valid` is low after that edge.
- R10: After reset, `disp_ready` is high and `iss_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties all slots in this cycle |
| disp_valid | input | 1 | An instruction is offered for dispatch |
| disp_ready | output | 1 | A free slot exists |
| disp_op | input | OP_W | Opcode of the offered instruction |
| disp_a_rdy | input | 1 | Source A value is present |
| disp_a_val | input | DATA_W | Source A value |
| disp_a_tag | input | TAG_W | Producer tag of source A when not present |
| disp_b_rdy | input | 1 | Source B value is present |
| disp_b_val | input | DATA_W | Source B value |
| disp_b_tag | input | TAG_W | Producer tag of source B when not present |
| disp_dst | input | TAG_W | Reorder-buffer slot for the result |
| cdb_valid | input | 1 | A result broadcast is on the bus |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_val | input | DATA_W | Value of the broadcast result |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_op | output | OP_W | Opcode of the issued instruction |
| iss_src_a | output | DATA_W | Source A value of the issued instruction |
| iss_src_b | output | DATA_W | Source B value of the issued instruction |
| iss_dst | output | TAG_W | Reorder-buffer destination of the issued instruction |

## Verification
The wakeup path is tested with several input patterns. Both operands present at dispatch gives the base issue latency. A single waiting operand is followed by a wrong-tag broadcast and then the right one, which separates a tag match from a mere bus event. Both operands waiting on one tag shows that one broadcast fills both. A ready operand whose unused tag field is later broadcast shows that a slot never overwrites a value it already has. A broadcast coinciding with dispatch tests the direct fill. The selection logic is tested by making three slots complete in the same cycle after the slots have been reused out of position order. Because the slots are reused, position order and dispatch order give different issue sequences. The full pool and a flush coinciding with both a ready slot and a new dispatch show that nothing is silently admitted or issued.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
  parameter int unsigned RSV_DEPTH_DEF  = 4;
  parameter int unsigned RSV_DATA_W_DEF = 16;
  parameter int unsigned RSV_TAG_W_DEF  = 4;
  parameter int unsigned RSV_OP_W_DEF   = 4;
  localparam int unsigned RSV_NUM_SRC   = 2;
endpackage

// File: rtl/rsv_operand.sv
module rsv_operand #(
  parameter int unsigned DATA_W = rsv_pkg::RSV_DATA_W_DEF,
  parameter int unsigned TAG_W  = rsv_pkg::RSV_TAG_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic              in_rdy,
  input  logic [DATA_W-1:0] in_val,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  output logic              rdy,
  output logic [DATA_W-1:0] val
);
  logic [TAG_W-1:0] tag_q;
  logic             hit_at_load;
  logic             hit_waiting;

  assign hit_at_load = cdb_valid && (cdb_tag == in_tag);
  assign hit_waiting = cdb_valid && !rdy && (cdb_tag == tag_q);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      rdy <= 1'b0;
    end else if (load) begin
      rdy <= in_rdy || hit_at_load;
    end else if (hit_waiting) begin
      rdy <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      tag_q <= in_tag;
      val   <= in_rdy ? in_val : cdb_val;
    end else if (hit_waiting) begin
      val <= cdb_val;
    end
  end
endmodule

// File: rtl/rsv_entry.sv
module rsv_entry #(
  parameter int unsigned DATA_W = rsv_pkg::RSV_DATA_W_DEF,
  parameter int unsigned TAG_W  = rsv_pkg::RSV_TAG_W_DEF,
  parameter int unsigned OP_W   = rsv_pkg::RSV_OP_W_DEF,
  localparam int unsigned NSRC  = rsv_pkg::RSV_NUM_SRC
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clear,
  input  logic                       load,
  input  logic                       take,
  input  logic [OP_W-1:0]            in_op,
  input  logic [TAG_W-1:0]           in_dst,
  input  logic [NSRC-1:0]            in_rdy,
  input  logic [NSRC-1:0][DATA_W-1:0] in_val,
  input  logic [NSRC-1:0][TAG_W-1:0] in_tag,
  input  logic                       cdb_valid,
  input  logic [TAG_W-1:0]           cdb_tag,
  input  logic [DATA_W-1:0]          cdb_val,
  output logic                       valid,
  output logic                       complete,
  output logic [OP_W-1:0]            op,
  output logic [TAG_W-1:0]           dst,
  output logic [NSRC-1:0][DATA_W-1:0] src_val
);
  logic [NSRC-1:0] src_rdy;

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    rsv_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd (
      .clk       (clk),
      .rst       (rst),
      .clear     (clear),
      .load      (load),
      .in_rdy    (in_rdy[s]),
      .in_val    (in_val[s]),
      .in_tag    (in_tag[s]),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_val   (cdb_val),
      .rdy       (src_rdy[s]),
      .val       (src_val[s])
    );
  end

  assign complete = &src_rdy;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (take) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      op  <= in_op;
      dst <= in_dst;
    end
  end
endmodule

// File: rtl/rsv_age_matrix.sv
module rsv_age_matrix #(
  parameter int unsigned DEPTH = rsv_pkg::RSV_DEPTH_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] alloc,
  output logic [DEPTH-1:0] older [DEPTH]
);
  // older[i][j] set: slot i was dispatched before slot j
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) older[i] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc[k]) begin
          for (int j = 0; j < DEPTH; j++) begin
            older[k][j] <= 1'b0;
            if (j != k) older[j][k] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rsv_select.sv
module rsv_select #(
  parameter int unsigned DEPTH = rsv_pkg::RSV_DEPTH_DEF
) (
  input  logic [DEPTH-1:0] req,
  input  logic [DEPTH-1:0] older [DEPTH],
  output logic [DEPTH-1:0] grant
);
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        blocked = blocked | (req[j] & older[j][i]);
      end
      grant[i] = req[i] & ~blocked;
    end
  end
endmodule

// File: rtl/rsv_station.sv
module rsv_station #(
  parameter int unsigned DEPTH  = rsv_pkg::RSV_DEPTH_DEF,
  parameter int unsigned DATA_W = rsv_pkg::RSV_DATA_W_DEF,
  parameter int unsigned TAG_W  = rsv_pkg::RSV_TAG_W_DEF,
  parameter int unsigned OP_W   = rsv_pkg::RSV_OP_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic [OP_W-1:0]   disp_op,
  input  logic              disp_a_rdy,
  input  logic [DATA_W-1:0] disp_a_val,
  input  logic [TAG_W-1:0]  disp_a_tag,
  input  logic              disp_b_rdy,
  input  logic [DATA_W-1:0] disp_b_val,
  input  logic [TAG_W-1:0]  disp_b_tag,
  input  logic [TAG_W-1:0]  disp_dst,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_val,
  output logic              iss_valid,
  output logic [OP_W-1:0]   iss_op,
  output logic [DATA_W-1:0] iss_src_a,
  output logic [DATA_W-1:0] iss_src_b,
  output logic [TAG_W-1:0]  iss_dst
);
  localparam int unsigned NSRC = rsv_pkg::RSV_NUM_SRC;

  logic [DEPTH-1:0]            ent_valid;
  logic [DEPTH-1:0]            ent_rdy;
  logic [OP_W-1:0]             ent_op  [DEPTH];
  logic [TAG_W-1:0]            ent_dst [DEPTH];
  logic [NSRC-1:0][DATA_W-1:0] ent_src [DEPTH];
  logic [DEPTH-1:0]            older   [DEPTH];
  logic [DEPTH-1:0]            free_oh;
  logic [DEPTH-1:0]            alloc_oh;
  logic [DEPTH-1:0]            grant;
  logic [DEPTH-1:0]            take;
  logic                        accept;

  logic [NSRC-1:0]             d_rdy;
  logic [NSRC-1:0][DATA_W-1:0] d_val;
  logic [NSRC-1:0][TAG_W-1:0]  d_tag;

  assign d_rdy = {disp_b_rdy, disp_a_rdy};
  assign d_val = {disp_b_val, disp_a_val};
  assign d_tag = {disp_b_tag, disp_a_tag};

  // lowest free slot position
  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!ent_valid[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign disp_ready = ~&ent_valid;
  assign accept     = disp_valid && disp_ready && !flush;
  assign alloc_oh   = free_oh & {DEPTH{accept}};

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    rsv_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_ent (
      .clk       (clk),
      .rst       (rst),
      .clear     (flush),
      .load      (alloc_oh[i]),
      .take      (take[i]),
      .in_op     (disp_op),
      .in_dst    (disp_dst),
      .in_rdy    (d_rdy),
      .in_val    (d_val),
      .in_tag    (d_tag),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_val   (cdb_val),
      .valid     (ent_valid[i]),
      .complete  (ent_rdy[i]),
      .op        (ent_op[i]),
      .dst       (ent_dst[i]),
      .src_val   (ent_src[i])
    );
  end

  rsv_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk   (clk),
    .rst   (rst),
    .alloc (alloc_oh),
    .older (older)
  );

  rsv_select #(.DEPTH(DEPTH)) u_sel (
    .req   (ent_valid & ent_rdy),
    .older (older),
    .grant (grant)
  );

  assign take = grant & {DEPTH{!flush}};

  logic [OP_W-1:0]   nx_op;
  logic [DATA_W-1:0] nx_a;
  logic [DATA_W-1:0] nx_b;
  logic [TAG_W-1:0]  nx_dst;

  always_comb begin
    nx_op  = '0;
    nx_a   = '0;
    nx_b   = '0;
    nx_dst = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (take[i]) begin
        nx_op  = nx_op  | ent_op[i];
        nx_a   = nx_a   | ent_src[i][0];
        nx_b   = nx_b   | ent_src[i][1];
        nx_dst = nx_dst | ent_dst[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) iss_valid <= 1'b0;
    else     iss_valid <= |take;
  end

  always_ff @(posedge clk) begin
    iss_op    <= nx_op;
    iss_src_a <= nx_a;
    iss_src_b <= nx_b;
    iss_dst   <= nx_dst;
  end
endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk #(
  parameter int unsigned DEPTH = rsv_pkg::RSV_DEPTH_DEF
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic [DEPTH-1:0] ent_valid,
  input logic [DEPTH-1:0] ent_rdy,
  input logic [DEPTH-1:0] alloc_oh,
  input logic [DEPTH-1:0] take,
  input logic             iss_valid
);
  p_occupancy_r1: assert property (@(posedge clk) disable iff (rst)
    !flush |=> $countones(ent_valid) ==
      $countones($past(ent_valid)) + $countones($past(alloc_oh)) - $countones($past(take)));

  p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> (ent_valid == '0) && !iss_valid);

  p_single_issue_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take));

  p_issue_has_source_r6: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> $past(take) != '0);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    p_take_complete_r6: assert property (@(posedge clk) disable iff (rst)
      take[i] |-> ent_valid[i] && ent_rdy[i]);

    p_no_overwrite_r2: assert property (@(posedge clk) disable iff (rst)
      alloc_oh[i] |-> !ent_valid[i]);

    p_ready_sticky_r5: assert property (@(posedge clk) disable iff (rst)
      (ent_valid[i] && ent_rdy[i] && !take[i] && !flush) |=> ent_valid[i] && ent_rdy[i]);
  end
endmodule

bind rsv_station rsv_station_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .ent_valid (ent_valid),
  .ent_rdy   (ent_rdy),
  .alloc_oh  (alloc_oh),
  .take      (take),
  .iss_valid (iss_valid)
);

// File: tb/rsv_station_tb.sv
`timescale 1ns/1ps
module rsv_station_tb;
  localparam int DEPTH = 4, DATA_W = 16, TAG_W = 4, OP_W = 4;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic disp_valid = 1'b0, disp_ready;
  logic [OP_W-1:0] disp_op = '0;
  logic disp_a_rdy = 1'b0, disp_b_rdy = 1'b0;
  logic [DATA_W-1:0] disp_a_val = '0, disp_b_val = '0;
  logic [TAG_W-1:0] disp_a_tag = '0, disp_b_tag = '0, disp_dst = '0;
  logic cdb_valid = 1'b0;
  logic [TAG_W-1:0] cdb_tag = '0;
  logic [DATA_W-1:0] cdb_val = '0;
  logic iss_valid;
  logic [OP_W-1:0] iss_op;
  logic [DATA_W-1:0] iss_src_a, iss_src_b;
  logic [TAG_W-1:0] iss_dst;

  int checks = 0, errors = 0, log_n = 0;
  int log_op [16], log_a [16], log_b [16], log_dst [16];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rsv_station #(.DEPTH(DEPTH), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_a_rdy(disp_a_rdy), .disp_a_val(disp_a_val), .disp_a_tag(disp_a_tag),
    .disp_b_rdy(disp_b_rdy), .disp_b_val(disp_b_val), .disp_b_tag(disp_b_tag),
    .disp_dst(disp_dst), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_val(cdb_val),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_src_a(iss_src_a),
    .iss_src_b(iss_src_b), .iss_dst(iss_dst));

  // record every issue shortly after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (!rst && iss_valid && log_n < 16) begin
      log_op[log_n] = iss_op;  log_a[log_n] = iss_src_a;
      log_b[log_n] = iss_src_b; log_dst[log_n] = iss_dst;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input int op, input bit ar, input int av, input int at,
                     input bit br, input int bv, input int bt, input int dst);
    disp_valid = 1'b1; disp_op = OP_W'(op);
    disp_a_rdy = ar; disp_a_val = DATA_W'(av); disp_a_tag = TAG_W'(at);
    disp_b_rdy = br; disp_b_val = DATA_W'(bv); disp_b_tag = TAG_W'(bt);
    disp_dst = TAG_W'(dst);
  endtask

  task automatic dispatch(input int op, input bit ar, input int av, input int at,
                          input bit br, input int bv, input int bt, input int dst);
    put(op, ar, av, at, br, bv, bt, dst);
    step(1);
    disp_valid = 1'b0;
  endtask

  task automatic bcast(input int tag, input int val);
    cdb_valid = 1'b1; cdb_tag = TAG_W'(tag); cdb_val = DATA_W'(val);
    step(1);
    cdb_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(disp_ready == 1'b1, "R10 disp_ready after reset", int'(disp_ready), 1);
    chk(iss_valid == 1'b0, "R10 iss_valid after reset", int'(iss_valid), 0);
  endtask

  task automatic t_basic();
    log_n = 0;
    dispatch(1, 1, 10, 0, 1, 20, 0, 3);
    chk(iss_valid == 1'b0, "R6 no issue one edge after dispatch", int'(iss_valid), 0);
    step(1);
    chk(iss_valid == 1'b1, "R6 issue two edges after dispatch", int'(iss_valid), 1);
    chk(iss_op == 1 && iss_src_a == 10 && iss_src_b == 20, "R1 R3 issued op and operands",
        int'(iss_src_a), 10);
    chk(iss_dst == 3, "R4 destination", int'(iss_dst), 3);
    step(2);
  endtask

  task automatic t_wait_tag();
    log_n = 0;
    dispatch(2, 0, 0, 5, 1, 30, 0, 6);
    step(3);
    chk(log_n == 0, "R6 R3 waiting operand blocks issue", log_n, 0);
    bcast(6, 99);
    step(2);
    chk(log_n == 0, "R5 wrong tag ignored", log_n, 0);
    bcast(5, 77);
    chk(iss_valid == 1'b0, "R6 not issued on capture edge", int'(iss_valid), 0);
    step(1);
    chk(iss_valid == 1'b1 && iss_src_a == 77 && iss_src_b == 30, "R5 captured value issued",
        int'(iss_src_a), 77);
    chk(iss_dst == 6, "R4 destination after wakeup", int'(iss_dst), 6);
    step(2);
    // both operands on one tag
    log_n = 0;
    dispatch(3, 0, 0, 2, 0, 0, 2, 7);
    bcast(2, 5);
    step(2);
    chk(log_n == 1 && log_a[0] == 5 && log_b[0] == 5, "R5 one broadcast fills both",
        log_b[0], 5);
    // ready operand not overwritten by broadcast of its stale tag
    log_n = 0;
    dispatch(4, 1, 11, 7, 0, 0, 8, 9);
    bcast(7, 500);
    step(2);
    chk(log_n == 0, "R5 ready operand tag does not complete slot", log_n, 0);
    bcast(8, 3);
    step(2);
    chk(log_n == 1 && log_a[0] == 11 && log_b[0] == 3, "R5 ready operand kept", log_a[0], 11);
  endtask

  task automatic t_bypass();
    log_n = 0;
    cdb_valid = 1'b1; cdb_tag = 4'd4; cdb_val = 16'd42;
    dispatch(5, 0, 0, 4, 1, 8, 0, 2);
    cdb_valid = 1'b0;
    step(1);
    chk(iss_valid == 1'b1 && iss_src_a == 42, "R7 same-cycle broadcast at dispatch",
        int'(iss_src_a), 42);
    step(2);
  endtask

  task automatic t_flush();
    log_n = 0;
    dispatch(7, 1, 1, 0, 1, 2, 0, 1);
    flush = 1'b1;
    put(8, 1, 3, 0, 1, 4, 0, 2);
    step(1);
    flush = 1'b0; disp_valid = 1'b0;
    chk(iss_valid == 1'b0, "R9 nothing issues in flush cycle", int'(iss_valid), 0);
    step(4);
    chk(log_n == 0, "R9 flushed slot and flush-cycle dispatch never issue", log_n, 0);
  endtask

  task automatic t_full();
    log_n = 0;
    for (int i = 0; i < DEPTH; i++) dispatch(i + 1, 0, 0, 10 + i, 1, 0, 0, i);
    chk(disp_ready == 1'b0, "R2 not ready when full", int'(disp_ready), 0);
    put(15, 1, 1, 0, 1, 1, 0, 15);
    step(2);
    disp_valid = 1'b0;
    step(2);
    chk(log_n == 0, "R2 offer while full dropped", log_n, 0);
    flush = 1'b1;
    step(1);
    flush = 1'b0;
    chk(disp_ready == 1'b1, "R9 pool empty after flush", int'(disp_ready), 1);
    for (int i = 0; i < DEPTH; i++) bcast(10 + i, 1);
    step(3);
    chk(log_n == 0, "R9 flushed waiting slots never issue", log_n, 0);
  endtask

  task automatic t_age();
    log_n = 0;
    dispatch(9, 1, 1, 0, 1, 1, 0, 0);      // slot 0, issues next edge
    dispatch(1, 0, 0, 10, 1, 100, 0, 11);   // slot 1
    dispatch(2, 0, 0, 10, 1, 200, 0, 12);   // reuses slot 0
    dispatch(3, 0, 0, 10, 1, 300, 0, 13);   // slot 2
    step(1);
    chk(log_n == 1 && log_op[0] == 9, "R1 first instruction issued", log_op[0], 9);
    log_n = 0;
    bcast(10, 55);
    step(4);
    chk(log_n == 3, "R8 one issue per cycle, all three issued", log_n, 3);
    chk(log_op[0] == 1 && log_op[1] == 2 && log_op[2] == 3, "R8 dispatch order kept",
        log_op[1], 2);
    chk(log_dst[0] == 11 && log_dst[2] == 13, "R4 destinations follow instructions",
        log_dst[2], 13);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_basic();
    t_wait_tag();
    t_bypass();
    t_flush();
    t_full();
    t_age();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule